// File: doc/BRIEF.md
# Zero-Suppressed Quasi-Random Line Test Generator

This block makes a serial quasi-random bit stream for testing T1/E1 lines. A 20-stage shift register moves one place on each cycle in which `step_en` is high. Stage 1 takes the exclusive-OR of stages 17 and 20. The stream is read from stage 20, except that the output is forced to one whenever interior stages 6 to 19 are all zero. This bounds any run of zeros on the line to at most 14 bits. A downstream overlay block adds the framing bits, data-link bits and CRC. This block supplies only the payload stream and holds it steady while `step_en` is low.

The register can be seeded in three ways. Reset seeds it with a fixed non-zero value. The `load_en` input writes any value the user chooses. If the register is ever found all zero, the block recovers by itself. A small controller has two named states. **SEEDING** writes the fixed seed and then moves to ACTIVE. It is entered on reset and on the transition *zero-found* from ACTIVE. **ACTIVE** loads, steps or holds the register. It leaves only on *zero-found*, which fires when the register is all zero and no load is requested. The transition *seed-done* from SEEDING back to ACTIVE is taken unconditionally.

Stage k is held in bit k-1 of the register. The `load_val` input therefore uses the same mapping: bit 0 is stage 1 and bit 19 is stage 20.

Top module: `qrs_gen`

## Requirements
- R1: While `rst_n` is low, the register holds the seed value 20'hACE01 and `bit_out` is 1. The first rising edge after reset is spent in SEEDING: the register does not advance, even with `step_en` high.
- R2: In ACTIVE, with `load_en` low and a non-zero register, each edge with `step_en` high shifts stage k into stage k+1 and loads stage 1 with stage 17 XOR stage 20.
- R3: In ACTIVE, with `load_en` and `step_en` both low, the register and `bit_out` hold their values.
- R4: `bit_out` equals stage 20 OR the NOR of stages 6 through 19 (bits 5 to 18 of `load_val` after a load).
- R5: In ACTIVE, `load_en` high writes `load_val` into the register on the next edge, and it overrides `step_en` in the same cycle.
- R6: If the register holds all zeros in ACTIVE and `load_en` is low, the controller moves to SEEDING. The edge after that writes the seed. `load_en` and `step_en` have no effect while in SEEDING.
- R7: Across any stepping sequence, `bit_out` never shows more than 14 consecutive zeros.
- R8: The sequence matches a bit-accurate model of the feedback over tens of thousands of steps; the unsuppressed register sequence has period 2^20 - 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; seeds the register |
| step_en | input | 1 | Advance the register by one place on this edge |
| load_en | input | 1 | Write `load_val` into the register on this edge |
| load_val | input | 20 | Value to write; bit k-1 is stage k |
| bit_out | output | 1 | Zero-suppressed quasi-random output bit |

## Verification
Two functions can fall in the same cycle:
- A load request together with a step request.
- A load request arriving while the controller is re-seeding after an all-zero state.

The bench provokes the first by raising both `load_en` and `step_en` with a value whose stepped output differs from its loaded output. It provokes the second by loading zero and then presenting a fresh load during the SEEDING cycle. In each case the following output bits are judged against the bench model: in the first they must follow the loaded value, and in the second they must follow the seed.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

    typedef enum logic [0:0] {
        ST_SEEDING = 1'b0,
        ST_ACTIVE  = 1'b1
    } state_t;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2,
        CMD_SEED = 2'd3
    } cmd_t;

endpackage

// File: rtl/qrs_shreg.sv
module qrs_shreg
    import qrs_pkg::*;
#(
    parameter int              N_STAGES = 20,
    parameter int              FB_TAP   = 17,
    parameter logic [N_STAGES-1:0] SEED_VAL = 20'hACE01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cmd_t                cmd,
    input  logic [N_STAGES-1:0] load_val,
    output logic [N_STAGES-1:0] stage_q
);
    localparam int LAST = N_STAGES - 1;
    localparam int TAPI = FB_TAP - 1;

    logic feedback;

    always_comb begin
        feedback = stage_q[TAPI] ^ stage_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= SEED_VAL;
        end else begin
            unique case (cmd)
                CMD_STEP: stage_q <= {stage_q[LAST-1:0], feedback};
                CMD_LOAD: stage_q <= load_val;
                CMD_SEED: stage_q <= SEED_VAL;
                default:  stage_q <= stage_q;
            endcase
        end
    end
endmodule

// File: rtl/qrs_suppress.sv
module qrs_suppress #(
    parameter int N_STAGES = 20,
    parameter int SUP_LO   = 6,
    parameter int SUP_HI   = 19
) (
    input  logic [N_STAGES-1:0] stage_q,
    output logic                bit_out
);
    localparam int LO_I = SUP_LO - 1;
    localparam int HI_I = SUP_HI - 1;

    logic window_clear;

    always_comb begin
        window_clear = ~|stage_q[HI_I:LO_I];
        bit_out      = stage_q[N_STAGES-1] | window_clear;
    end
endmodule

// File: rtl/qrs_ctrl.sv
module qrs_ctrl
    import qrs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_en,
    input  logic   load_en,
    input  logic   reg_zero,
    output state_t state_q,
    output cmd_t   cmd
);
    state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEDING;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cmd     = CMD_HOLD;
        unique case (state_q)
            ST_SEEDING: begin
                cmd     = CMD_SEED;
                state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (load_en) begin
                    cmd = CMD_LOAD;
                end else if (reg_zero) begin
                    state_d = ST_SEEDING;
                end else if (step_en) begin
                    cmd = CMD_STEP;
                end
            end
            default: begin
                state_d = ST_SEEDING;
            end
        endcase
    end
endmodule

// File: rtl/qrs_gen.sv
module qrs_gen
    import qrs_pkg::*;
#(
    parameter int              N_STAGES = 20,
    parameter int              FB_TAP   = 17,
    parameter int              SUP_LO   = 6,
    parameter int              SUP_HI   = 19,
    parameter logic [N_STAGES-1:0] SEED_VAL = 20'hACE01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic                load_en,
    input  logic [N_STAGES-1:0] load_val,
    output logic                bit_out
);
    logic [N_STAGES-1:0] stage_q;
    logic                reg_zero;
    state_t              fsm_state;
    cmd_t                cmd;

    always_comb begin
        reg_zero = ~|stage_q;
    end

    qrs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .load_en  (load_en),
        .reg_zero (reg_zero),
        .state_q  (fsm_state),
        .cmd      (cmd)
    );

    qrs_shreg #(
        .N_STAGES (N_STAGES),
        .FB_TAP   (FB_TAP),
        .SEED_VAL (SEED_VAL)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .load_val (load_val),
        .stage_q  (stage_q)
    );

    qrs_suppress #(
        .N_STAGES (N_STAGES),
        .SUP_LO   (SUP_LO),
        .SUP_HI   (SUP_HI)
    ) u_supp (
        .stage_q  (stage_q),
        .bit_out  (bit_out)
    );
endmodule

// File: rtl/qrs_gen_chk.sv
module qrs_gen_chk
    import qrs_pkg::*;
#(
    parameter int              N_STAGES = 20,
    parameter int              FB_TAP   = 17,
    parameter int              SUP_LO   = 6,
    parameter int              SUP_HI   = 19,
    parameter logic [N_STAGES-1:0] SEED_VAL = 20'hACE01
) (
    input logic                clk,
    input logic                rst_n,
    input logic                step_en,
    input logic                load_en,
    input logic [N_STAGES-1:0] load_val,
    input logic [N_STAGES-1:0] stage_q,
    input state_t              fsm_state,
    input logic                bit_out
);
    localparam int MAX_RUN = SUP_HI - SUP_LO + 1;

    logic [5:0] zrun;
    logic       live;

    always_comb begin
        live = (fsm_state == ST_ACTIVE) && !load_en && (stage_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zrun <= '0;
        end else if (!live) begin
            zrun <= '0;
        end else if (step_en) begin
            zrun <= bit_out ? 6'd0 : zrun + 6'd1;
        end
    end

    // R2
    step_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && step_en) |=>
        stage_q == {$past(stage_q[N_STAGES-2:0]),
                    $past(stage_q[FB_TAP-1] ^ stage_q[N_STAGES-1])});

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !step_en) |=> ($stable(stage_q) && $stable(bit_out)));

    // R5
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_ACTIVE && load_en) |=> stage_q == $past(load_val));

    // R6
    zero_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_ACTIVE && !load_en && stage_q == '0) |=>
        (fsm_state == ST_SEEDING && stage_q == '0));

    // R1, R6
    seed_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SEEDING) |=>
        (fsm_state == ST_ACTIVE && stage_q == SEED_VAL));

    // R7
    zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zrun <= 6'(MAX_RUN));
endmodule

bind qrs_gen qrs_gen_chk #(
    .N_STAGES (N_STAGES),
    .FB_TAP   (FB_TAP),
    .SUP_LO   (SUP_LO),
    .SUP_HI   (SUP_HI),
    .SEED_VAL (SEED_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .load_en   (load_en),
    .load_val  (load_val),
    .stage_q   (stage_q),
    .fsm_state (fsm_state),
    .bit_out   (bit_out)
);

// File: tb/qrs_gen_bench.sv
module qrs_gen_bench;
    localparam logic [19:0] SEED = 20'hACE01;
    localparam int LONG_RUN = 60000;

    // {load value, expected bit_out right after the load} -- R4
    localparam logic [20:0] VEC [0:7] = '{
        {20'h80000, 1'b1},
        {20'h00001, 1'b1},
        {20'h00020, 1'b0},
        {20'h40000, 1'b0},
        {20'h0001F, 1'b1},
        {20'h7FFE0, 1'b0},
        {20'hFFFFF, 1'b1},
        {20'h00400, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        load_en = 1'b0;
    logic [19:0] load_val = '0;
    logic        bit_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [19:0] m;

    always #2 clk = ~clk;

    qrs_gen #(.SEED_VAL(SEED)) u_qrs_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .load_en  (load_en),
        .load_val (load_val),
        .bit_out  (bit_out)
    );

    function automatic logic [19:0] nxt(input logic [19:0] s);
        return {s[18:0], s[16] ^ s[19]};
    endfunction

    function automatic logic outb(input logic [19:0] s);
        return s[19] | ~|s[18:5];
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: bit_out=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: finished=0 expected=1");
        finish_run();
    end

    initial begin
        int run;
        int worst;
        @(negedge clk);
        step_en = 1'b1;
        tick();
        chk(bit_out, 1'b1, "R1 reset output");

        // R1: first edge after reset spent seeding, no advance
        rst_n = 1'b1;
        tick();
        m = SEED;
        chk(bit_out, outb(m), "R1 no advance after reset");
        for (int i = 0; i < 40; i++) begin
            tick();
            m = nxt(m);
            chk(bit_out, outb(m), "R2 early steps");
        end

        // R4 table walk
        step_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            load_en  = 1'b1;
            load_val = VEC[i][20:1];
            tick();
            chk(bit_out, VEC[i][0], "R4 output forcing");
        end
        load_en = 1'b0;

        // R5: load and step together, load wins
        load_en  = 1'b1;
        step_en  = 1'b1;
        load_val = 20'h40000;
        tick();
        chk(bit_out, 1'b0, "R5 load over step");
        load_en = 1'b0;
        tick();
        chk(bit_out, 1'b1, "R5 step after load");
        m = nxt(20'h40000);

        // R3: hold
        step_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(bit_out, outb(m), "R3 hold");
        end
        step_en = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tick();
            m = nxt(m);
            chk(bit_out, outb(m), "R3 resume");
        end

        // R6: zero recovery, load during SEEDING ignored
        load_en  = 1'b1;
        load_val = 20'h00000;
        tick();
        chk(bit_out, 1'b1, "R6 zero forced output");
        load_en = 1'b0;
        tick();
        chk(bit_out, 1'b1, "R6 zero found");
        load_en  = 1'b1;
        load_val = 20'h40000;
        tick();
        m = SEED;
        chk(bit_out, outb(m), "R6 seed written");
        load_en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            tick();
            m = nxt(m);
            chk(bit_out, outb(m), "R6 after recovery");
        end

        // R8 long run with R7 zero-run tracking
        run = 0;
        worst = 0;
        for (int i = 0; i < LONG_RUN; i++) begin
            tick();
            m = nxt(m);
            if (bit_out !== outb(m)) begin
                chk(bit_out, outb(m), "R8 model match");
            end
            run = (bit_out == 1'b0) ? run + 1 : 0;
            if (run > worst) worst = run;
        end
        total++;
        if (worst > 14) begin
            bad++;
            $display("FAIL R7: longest zero run=%0d expected<=14", worst);
        end
        total++;
        if (worst < 1) begin
            bad++;
            $display("FAIL R8: longest zero run=%0d expected>=1", worst);
        end

        finish_run();
    end
endmodule